// File: doc/BRIEF.md
# Burst Test Pulse Generator

This block drives a single test line with a short train of square-wave pulses, used to exercise the channel inputs of a timing front end during functional checks. A one-cycle start strobe launches a burst. Two 2-bit fields choose the burst shape: one sets how many full cycles the burst contains, the other sets the length of each half period. An active flag stays high for the whole burst, so that surrounding control logic knows when the line is in use.

The block runs from one reference clock. The clock period is a parameter given in picoseconds. At elaboration, each of the four nominal half-period durations is turned into a whole number of clock counts, rounded to the nearest count and never below one. Both configuration fields are captured on the accepted strobe. A strobe that arrives while a burst is running is dropped.

Top module: `tp_burst_gen`

## Requirements
- R1: While reset is high, and after it is released with no strobe, `pulse_o` and `active_o` are both low.
- R2: A strobe sampled while `active_o` is low sets both `pulse_o` and `active_o` high in the next cycle. Nothing else starts a burst.
- R3: Each half period lasts round(T / clock period) cycles, at least 1. T is chosen by `half_sel_i`: code 0 gives 125 ns, code 1 gives 250 ns, code 2 gives 1000 ns and code 3 gives 2000 ns. With the default 5 ns clock these are 25, 50, 200 and 400 cycles.
- R4: A burst contains 2^`cyc_sel_i` rising edges of `pulse_o`: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8.
- R5: Every high phase and every low phase of a burst has the same length, so the duty cycle is 50%.
- R6: `active_o` stays high for exactly 2·N·H cycles, where N is the cycle count and H the half-period length. It falls at the end of the final low half. `pulse_o` is never high while `active_o` is low.
- R7: A strobe sampled while `active_o` is high is ignored. This includes the final cycle of a burst. The burst keeps its length and shape, and no new burst follows.
- R8: The configuration fields are sampled only on the accepted strobe. Changing them during a burst does not affect that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst start strobe |
| cyc_sel_i | input | 2 | Burst length code (1, 2, 4 or 8 cycles) |
| half_sel_i | input | 2 | Half-period code (125, 250, 1000 or 2000 ns) |
| pulse_o | output | 1 | Test pulse line, registered |
| active_o | output | 1 | High while a burst is in progress, registered |

## Verification
The checker assumes that the configuration fields and the strobe are only meaningful at clock edges. It assumes the strobe is a plain level that the block samples on its own, with no handshake. It also assumes a phase is never longer than its 16-bit length counters can hold. The stimulus changes inputs only on the falling clock edge. It raises the strobe and changes both fields in the middle of a burst and in the final cycle of a burst, so the drop rule and the capture rule are exercised under live traffic. All half periods chosen stay at or below 400 cycles.

// File: rtl/tp_burst_pkg.sv
package tp_burst_pkg;
  localparam int SEL_W       = 2;
  localparam int NUM_SEL     = 1 << SEL_W;
  localparam int MAX_CYC_LOG = NUM_SEL - 1;
  // halves in the longest burst minus one: 2*2^MAX_CYC_LOG - 1
  localparam int HALVES_W    = MAX_CYC_LOG + 1;

  typedef logic [SEL_W-1:0] sel_t;

  // nearest whole clock count for a duration in ns, never below one
  function automatic int unsigned ns_to_counts(input int unsigned ns,
                                               input int unsigned clk_ps);
    int unsigned r;
    r = (ns * 1000 + clk_ps / 2) / clk_ps;
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/tp_cfg_decode.sv
module tp_cfg_decode
  import tp_burst_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int CLK_PS   = 5000,
  parameter int HALF0_NS = 125,
  parameter int HALF1_NS = 250,
  parameter int HALF2_NS = 1000,
  parameter int HALF3_NS = 2000
) (
  input  sel_t                half_sel_i,
  input  sel_t                cyc_sel_i,
  output logic [CNT_W-1:0]    hp_last_o,
  output logic [HALVES_W-1:0] halves_last_o
);
  localparam int unsigned HALF_NS [NUM_SEL] = '{HALF0_NS, HALF1_NS, HALF2_NS, HALF3_NS};

  logic [CNT_W-1:0]    hp_tab [NUM_SEL];
  logic [HALVES_W-1:0] hv_tab [NUM_SEL];

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tab
    assign hp_tab[g] = CNT_W'(ns_to_counts(HALF_NS[g], CLK_PS) - 1);
    assign hv_tab[g] = HALVES_W'((2 << g) - 1);
  end

  assign hp_last_o     = hp_tab[half_sel_i];
  assign halves_last_o = hv_tab[cyc_sel_i];
endmodule

// File: rtl/tp_half_timer.sv
module tp_half_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      reload_q <= load_val_i;
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tp_half_count.sv
module tp_half_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic         last_o
);
  logic [W-1:0] rem_q;

  assign last_o = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                          rem_q <= '0;
    else if (load_i)                  rem_q <= load_val_i;
    else if (step_i && rem_q != '0)   rem_q <= rem_q - 1'b1;
  end
endmodule

// File: rtl/tp_burst_gen.sv
module tp_burst_gen
  import tp_burst_pkg::*;
#(
  parameter int CLK_PS   = 5000,
  parameter int HALF0_NS = 125,
  parameter int HALF1_NS = 250,
  parameter int HALF2_NS = 1000,
  parameter int HALF3_NS = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [1:0] cyc_sel_i,
  input  logic [1:0] half_sel_i,
  output logic       pulse_o,
  output logic       active_o
);
  localparam int unsigned MAX_CNT = max4(ns_to_counts(HALF0_NS, CLK_PS),
                                         ns_to_counts(HALF1_NS, CLK_PS),
                                         ns_to_counts(HALF2_NS, CLK_PS),
                                         ns_to_counts(HALF3_NS, CLK_PS));
  localparam int CNT_W = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT);

  logic                active_q, pulse_q;
  logic                accept, tick, last;
  logic [CNT_W-1:0]    hp_last;
  logic [HALVES_W-1:0] halves_last;

  assign accept = start_i && !active_q;

  tp_cfg_decode #(
    .CNT_W(CNT_W), .CLK_PS(CLK_PS),
    .HALF0_NS(HALF0_NS), .HALF1_NS(HALF1_NS),
    .HALF2_NS(HALF2_NS), .HALF3_NS(HALF3_NS)
  ) u_dec (
    .half_sel_i   (half_sel_i),
    .cyc_sel_i    (cyc_sel_i),
    .hp_last_o    (hp_last),
    .halves_last_o(halves_last)
  );

  tp_half_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (accept),
    .load_val_i(hp_last),
    .run_i     (active_q),
    .tick_o    (tick)
  );

  tp_half_count #(.W(HALVES_W)) u_halves (
    .clk       (clk),
    .rst       (rst),
    .load_i    (accept),
    .load_val_i(halves_last),
    .step_i    (tick),
    .last_o    (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else if (accept) begin
      active_q <= 1'b1;
      pulse_q  <= 1'b1;
    end else if (tick) begin
      if (last) begin
        active_q <= 1'b0;
        pulse_q  <= 1'b0;
      end else begin
        pulse_q <= ~pulse_q;
      end
    end
  end

  assign pulse_o  = pulse_q;
  assign active_o = active_q;
endmodule

// File: rtl/tp_burst_gen_chk.sv
module tp_burst_gen_chk #(
  parameter int LEN_W = 16
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic pulse_o,
  input logic active_o
);
  logic             pulse_d, active_d;
  logic [LEN_W-1:0] hi_len, lo_len, hi_ref;
  logic [4:0]       rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_d  <= 1'b0;
      active_d <= 1'b0;
      hi_len   <= '0;
      lo_len   <= '0;
      hi_ref   <= '0;
      rise_cnt <= '0;
    end else begin
      pulse_d  <= pulse_o;
      active_d <= active_o;
      if (active_o && pulse_o)  hi_len <= pulse_d ? hi_len + 1'b1 : LEN_W'(1);
      if (active_o && !pulse_o) lo_len <= pulse_d ? LEN_W'(1) : lo_len + 1'b1;
      if (active_o && !pulse_o && pulse_d) hi_ref <= hi_len;
      if (!active_o) rise_cnt <= '0;
      else if (pulse_o && !pulse_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  // R6
  pulse_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> active_o);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !active_o) |=> (pulse_o && active_o));

  // R2
  start_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> $past(start_i));

  // R5
  equal_halves_chk: assert property (@(posedge clk) disable iff (rst)
    ((pulse_o && !pulse_d && active_d) || (!active_o && active_d)) |-> (lo_len == hi_ref));

  // R4
  burst_count_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_o && active_d) |-> ($onehot(rise_cnt) && rise_cnt <= 5'd8));
endmodule

bind tp_burst_gen tp_burst_gen_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .pulse_o (pulse_o),
  .active_o(active_o)
);

// File: tb/tp_burst_gen_test.sv
`timescale 1ns/1ps
module tp_burst_gen_test;
  localparam int CLK_NS = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] cyc_sel_i = 2'd0;
  logic [1:0] half_sel_i = 2'd0;
  logic       pulse_o, active_o;

  int checks = 0;
  int errors = 0;

  tp_burst_gen #(.CLK_PS(CLK_NS * 1000)) uut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .cyc_sel_i(cyc_sel_i), .half_sel_i(half_sel_i),
    .pulse_o(pulse_o), .active_o(active_o)
  );

  always #(CLK_NS / 2.0) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_half(input int sel);
    int ns;
    case (sel)
      0: ns = 125;
      1: ns = 250;
      2: ns = 1000;
      default: ns = 2000;
    endcase
    return (ns + CLK_NS / 2) / CLK_NS;
  endfunction

  // disturb 1: R7/R8 strobe and new fields mid-burst; 2: strobe in final active cycle
  task automatic run_burst(input int cyc, input int half, input int disturb);
    int hp, n, total, act, seg, rises, bad_seg;
    bit prev;
    hp = exp_half(half);
    n  = 1 << cyc;
    total = 2 * n * hp;
    @(negedge clk);
    cyc_sel_i = 2'(cyc); half_sel_i = 2'(half); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2
    check(pulse_o && active_o, "R2", {30'd0, pulse_o, active_o}, 3);
    act = 0; seg = 0; rises = 1; bad_seg = 0; prev = 1'b1;
    for (int i = 0; i < 20000; i++) begin
      if (!active_o) break;
      if (pulse_o && !active_o) bad_seg++;
      act++;
      if (pulse_o != prev) begin
        if (seg != hp) bad_seg++;
        seg = 0;
        if (pulse_o) rises++;
      end
      seg++;
      prev = pulse_o;
      start_i = 1'b0;
      if (disturb == 1 && act == 3) begin
        start_i = 1'b1; cyc_sel_i = ~cyc_sel_i; half_sel_i = ~half_sel_i;
      end
      if (disturb == 2 && act == total) start_i = 1'b1;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (seg != hp) bad_seg++;
    // R3 and R5: every phase equals the expected half period
    check(bad_seg == 0, "R3/R5", bad_seg, 0);
    // R4
    check(rises == n, "R4", rises, n);
    // R6
    check(act == total, "R6", act, total);
    check(!pulse_o, "R6", int'(pulse_o), 0);
    if (disturb != 0) begin
      @(negedge clk);
      // R7: ignored strobe must not start another burst
      check(!active_o && !pulse_o, "R7", {30'd0, pulse_o, active_o}, 0);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!pulse_o && !active_o, "R1", {30'd0, pulse_o, active_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!pulse_o && !active_o, "R1", {30'd0, pulse_o, active_o}, 0);
    for (int c = 0; c < 4; c++) run_burst(c, 0, 0);  // R4 all codes
    for (int h = 1; h < 4; h++) run_burst(1, h, 0);  // R3 all codes
    run_burst(2, 1, 1);  // R7 and R8 mid-burst
    run_burst(0, 2, 2);  // R7 in the last cycle
    run_burst(3, 0, 0);  // back-to-back start right after previous end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule